// File: doc/BRIEF.md
# Bus-Mapped ADC Control Port

This peripheral sits on a PC-style 10-bit I/O bus and gives a processor control of an external analog-to-digital converter. It claims the prototype-card window 0x300 to 0x31F. Inside that window, address bits 4 to 1 choose among three ports:

- the result port at 0x300;
- the start and status port at 0x302;
- the interrupt acknowledge port at 0x304.

Address bit 0 chooses the byte lane. A cycle with the DMA flag raised is never decoded.

Software can work in either of two ways:

- **Polling.** Write 0x302 to start a conversion. Read 0x302 until bit 0 drops. Then read the result at 0x300.
- **Interrupts.** Each end-of-conversion edge sets an interrupt flag. The service routine clears the flag with a write to 0x304, reads the result, and writes 0x302 again to start the next conversion.

The bus strobes are sampled on the block clock. The end-of-conversion input is asynchronous and is synchronised inside the block.

Top module: `adc_bus_port`

## Requirements
- R1: A read is decoded only when address bits 9..5 equal 11000b (0x300..0x31F) and bits 4..1 are 0 (result port) or 1 (status port). In that case `rd_en` is 1 in the same cycle as `bus_rd`.
- R2: While `bus_aen` is 1, no read is decoded, no start pulse is produced, and a write to the acknowledge port leaves `intr` unchanged.
- R3: When a write strobe is decoded with bits 4..1 equal to 1, `adc_start` goes high for exactly one clock, at the first clock edge of the strobe. Only one pulse is produced per strobe, however long the strobe lasts.
- R4: In a status read, bit 0 is 1 from the start pulse until the synchronised end-of-conversion edge, and 0 otherwise. Bits 15..1 of the status read are 0.
- R5: A result read with bit 0 = 0 returns `adc_result` zero-extended to 16 bits.
- R6: A result read with bit 0 = 1 returns bits 15..8 of the zero-extended result word in bits 7..0, with bits 15..8 zero.
- R7: A rising edge on `adc_eoc` sets `intr` at the third clock edge after the rise. The flag is set once per rising edge and holds until it is acknowledged.
- R8: When a write strobe is decoded with bits 4..1 equal to 2, `intr` clears at the strobe's first edge. If a new end-of-conversion edge lands on that same clock edge, the set wins.
- R9: When no read is decoded, `rd_en` is 0 and `rd_data` is 0.
- R10: After reset, `intr`, `adc_start` and the busy status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | I/O address |
| bus_aen | input | 1 | DMA cycle flag; 1 blocks decoding |
| bus_rd | input | 1 | I/O read strobe, active high |
| bus_wr | input | 1 | I/O write strobe, active high |
| rd_data | output | 16 | Read data, zero when idle |
| rd_en | output | 1 | Drive enable for the data bus |
| adc_start | output | 1 | One-clock conversion start pulse |
| adc_eoc | input | 1 | Asynchronous end of conversion |
| adc_result | input | RES_BITS | Converter result |
| intr | output | 1 | Interrupt request |

## Verification
The bench sweeps every address with `bus_aen` at both values. A decoder that ignores `bus_aen`, or compares too few address bits, shows up as stray bus drive or stray start pulses on aliases outside the window.

Every 10-bit result value is read in both byte lanes. A wrong lane shift or a missing zero-extension shows up as wrong upper bits.

The interrupt tests check each of the following:
- `intr` rises on the third edge after the end-of-conversion input goes high, so a missing or extra synchroniser stage is caught.
- A long end-of-conversion level sets the flag only once.
- An acknowledge issued with `bus_aen` high, or to a neighbouring port, does not clear the flag.
- When the set and the acknowledge fall on the same edge, the set wins.

// File: rtl/adc_bus_port.sv
module adc_bus_port #(
  parameter int RES_BITS = 10,
  parameter logic [4:0] CARD_BLOCK = 5'b11000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [9:0]          bus_addr,
  input  logic                bus_aen,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output logic [15:0]         rd_data,
  output logic                rd_en,
  output logic                adc_start,
  input  logic                adc_eoc,
  input  logic [RES_BITS-1:0] adc_result,
  output logic                intr
);
  localparam logic [3:0] PORT_DATA = 4'd0;
  localparam logic [3:0] PORT_CTRL = 4'd1;
  localparam logic [3:0] PORT_ACK  = 4'd2;

  logic       hit, wr_go, wr_ack, go_d, ack_d, go_edge, ack_edge;
  logic       busy, eoc_rise;
  logic [2:0] eoc_s;
  logic [3:0] port;
  logic [15:0] word, lane;

  assign hit  = !bus_aen && (bus_addr[9:5] == CARD_BLOCK);
  assign port = bus_addr[4:1];

  assign wr_go    = hit && bus_wr && (port == PORT_CTRL);
  assign wr_ack   = hit && bus_wr && (port == PORT_ACK);
  assign go_edge  = wr_go && !go_d;
  assign ack_edge = wr_ack && !ack_d;
  assign eoc_rise = eoc_s[1] && !eoc_s[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_d      <= 1'b0;
      ack_d     <= 1'b0;
      eoc_s     <= 3'b000;
      adc_start <= 1'b0;
      busy      <= 1'b0;
      intr      <= 1'b0;
    end else begin
      go_d      <= wr_go;
      ack_d     <= wr_ack;
      eoc_s     <= {eoc_s[1:0], adc_eoc};
      adc_start <= go_edge;
      if (go_edge)       busy <= 1'b1;
      else if (eoc_rise) busy <= 1'b0;
      if (eoc_rise)      intr <= 1'b1;
      else if (ack_edge) intr <= 1'b0;
    end
  end

  assign rd_en   = hit && bus_rd && (port == PORT_DATA || port == PORT_CTRL);
  assign word    = (port == PORT_CTRL) ? {15'b0, busy} : 16'(adc_result);
  assign lane    = bus_addr[0] ? {8'b0, word[15:8]} : word;
  assign rd_data = rd_en ? lane : 16'b0;

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);
  p_status_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port == PORT_CTRL) |-> (rd_data[15:1] == 15'b0));
  p_aen_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_aen |-> !rd_en);
  p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 16'b0));
  p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && !ack_edge) |=> intr);
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_edge && !eoc_rise) |=> !intr);
endmodule

// File: tb/tb_adc_bus_port.sv
module tb_adc_bus_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic bus_aen = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, adc_eoc = 1'b0;
  logic [9:0] adc_result = '0;
  logic [15:0] rd_data;
  logic rd_en, adc_start, intr;
  int n_cmp = 0, n_bad = 0, starts = 0;

  always #4 clk = ~clk;

  adc_bus_port dut (.clk, .rst_n, .bus_addr, .bus_aen, .bus_rd, .bus_wr,
    .rd_data, .rd_en, .adc_start, .adc_eoc, .adc_result, .intr);

  always @(posedge clk) if (adc_start) starts <= starts + 1;

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(int a, bit aen);
    @(negedge clk); bus_addr = 10'(a); bus_aen = aen; bus_wr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); bus_wr = 1'b0; bus_aen = 1'b0;
    @(posedge clk);
  endtask

  task automatic rd(int a, bit aen, output logic [15:0] d, output logic e);
    @(negedge clk); bus_addr = 10'(a); bus_aen = aen; bus_rd = 1'b1;
    #1; d = rd_data; e = rd_en;
    @(negedge clk); bus_rd = 1'b0; bus_aen = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d; logic e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 intr", intr, 0); chk("R10 start", adc_start, 0);
    rst_n = 1'b1;
    rd(10'h302, 0, d, e); chk("R10 busy", d, 0);

    adc_result = 10'h2A5;
    for (int a = 0; a < 1024; a++) begin
      for (int aen = 0; aen < 2; aen++) begin
        bit win;
        int p;
        win = (aen == 0) && (a >= 'h300) && (a <= 'h31F);
        p = (a >> 1) & 15;
        rd(a, aen[0], d, e);
        chk(aen ? "R2 rd_en" : "R1 rd_en", e, win && (p < 2));
        if (!(win && p < 2)) chk("R9 idle data", d, 0);
      end
    end

    for (int v = 0; v < 1024; v++) begin
      adc_result = 10'(v);
      rd(10'h300, 0, d, e); chk("R5 word", d, v);
      rd(10'h301, 0, d, e); chk("R6 upper lane", d, v >> 8);
    end

    for (int a = 'h2E0; a < 'h340; a++) begin
      for (int aen = 0; aen < 2; aen++) begin
        int s0;
        s0 = starts;
        wr(a, aen[0]);
        chk(aen ? "R2 start" : "R3 start count", starts - s0,
            (aen == 0 && a >= 'h300 && a <= 'h31F && ((a >> 1) & 15) == 1) ? 1 : 0);
      end
    end

    @(negedge clk); adc_eoc = 1'b1; @(negedge clk); adc_eoc = 1'b0;
    repeat (4) @(negedge clk);
    wr(10'h304, 0);
    wr(10'h302, 0);
    rd(10'h302, 0, d, e); chk("R4 busy high", d, 1);
    rd(10'h303, 0, d, e); chk("R4 status upper lane", d, 0);

    @(negedge clk); adc_eoc = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 intr before third edge", intr, 0);
    @(negedge clk);
    chk("R7 intr at third edge", intr, 1);
    rd(10'h302, 0, d, e); chk("R4 busy cleared", d, 0);

    repeat (20) @(negedge clk);
    wr(10'h304, 1); chk("R2 ack ignored", intr, 1);
    wr(10'h306, 0); chk("R8 other port no clear", intr, 1);
    wr(10'h304, 0); chk("R8 ack clears", intr, 0);
    repeat (10) @(negedge clk);
    chk("R7 level sets once", intr, 0);

    adc_eoc = 1'b0;
    repeat (4) @(negedge clk);
    adc_eoc = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 10'h304; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R8 set wins", intr, 1);
    wr(10'h305, 0); chk("R8 ack odd byte", intr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule